// File: doc/BRIEF.md
# Word-Bus Exact-Cycle I/O Sequencer

This block sits between a processor's load/store path and a 16-bit, word-oriented peripheral bus. It accepts a 1-, 2- or 3-byte access at any byte address in I/O space. It turns that access into the smallest correct series of bus cycles. Peripheral reads can have side effects, so the sequencer never touches a location the request did not name. It never emulates a byte write with a word read-modify-write. Reads on the bus are always full words. The requester gets them back in a 32-bit result and extracts the bytes it wants.

Each bus cycle is a request/acknowledge exchange. A per-cycle timeout ends a sequence whose target never answers and reports a bus error. A one-cycle completion strobe closes every sequence, whether it ended normally or was aborted. Interrupt logic uses this strobe to re-evaluate priority.

Top module: `iows_seq`

## Requirements
- R1: While and right after reset, `busy`, `done`, `err`, `bus_req`, `bus_write` and `bus_byte` are 0 and `rd_data` is 0.
- R2: A read with length L at address A uses exactly one word cycle when L + A[0] <= 2. The cycle goes to A with bit 0 cleared. The word lands in `rd_data[31:16]` when A[1] = 1 and in `rd_data[15:0]` otherwise; the other half is zero.
- R3: Any other read uses two word cycles, first at A with bit 0 cleared and then at that address + 2. `rd_data` = (second word << 16) | first word.
- R4: Every read cycle is a word cycle (`bus_byte` = 0), and no read is ever issued during a write request.
- R5: A 1-byte write is one byte cycle at A. The byte is in `bus_wdata[7:0]` and `bus_wdata[15:8]` is 0.
- R6: A 2-byte write at even A is one word cycle carrying data[15:0]. At odd A it is two byte cycles: data[7:0] at A, then data[15:8] at A+1.
- R7: A 3-byte write at odd A is a byte cycle (data[7:0] at A) followed by a word cycle (data[23:8] at A+1). At even A it is a word cycle (data[15:0] at A) followed by a byte cycle (data[23:16] at A+2).
- R8: `bus_req` stays high with `bus_addr`, `bus_write`, `bus_byte` and `bus_wdata` unchanged until `bus_ack` is sampled high. The next cycle, or completion, follows directly after that acknowledge.
- R9: If no acknowledge arrives within `TIMEOUT_CYC` clock cycles of `bus_req` being high, the sequence aborts. `bus_req` falls, and `done` and `err` pulse together for one cycle.
- R10: `done` is a single-cycle strobe in the cycle after the final acknowledge. In that cycle `busy` is 0 and `rd_data` holds the read result.
- R11: A request with `req_len` = 0 is ignored: no bus cycle and no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request, taken when `busy` is 0 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_len | input | 2 | Byte count 1..3 (0 is ignored) |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | 24 | Right-aligned write data |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | Timeout abort, pulses with `done` |
| rd_data | output | 32 | Read result, word(s) placed per R2/R3 |
| bus_req | output | 1 | Bus cycle request |
| bus_write | output | 1 | Bus cycle is a write |
| bus_byte | output | 1 | Bus cycle is a byte cycle |
| bus_addr | output | ADDR_W | Bus byte address (bit 0 clear on word cycles) |
| bus_wdata | output | 16 | Bus write data |
| bus_ack | input | 1 | Bus cycle acknowledge |
| bus_rdata | input | 16 | Bus read word, valid with `bus_ack` |

## Verification
Reads run at every byte offset within a longword, with all three lengths. This separates the one-word cases from the two-word cases and catches a wrong half-placement or a read that runs one word too far. Writes cover the same offset-by-length grid, which checks cycle count, byte-versus-word type, order and data slicing for each of the five split forms. Varying the acknowledge latency shows that cycle fields hold while they wait. A target that never answers checks the exact timeout length and the error strobe. A zero-length request shows that nothing reaches the bus.

// File: rtl/iows_pkg.sv
package iows_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUS  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic        wr;
        logic        byte_c;
        logic [1:0]  off;
        logic        hi_lane;
        logic [15:0] wdata;
    } bus_step_t;

    function automatic bus_step_t mk_step(input logic wr, input logic byte_c,
                                          input logic [1:0] off, input logic hi,
                                          input logic [15:0] d);
        bus_step_t s;
        s.wr      = wr;
        s.byte_c  = byte_c;
        s.off     = off;
        s.hi_lane = hi;
        s.wdata   = d;
        return s;
    endfunction

    // Reads span two words when length plus the odd-byte bit exceeds a word.
    function automatic logic read_spans_two(input logic [1:0] len, input logic a0);
        return ({1'b0, len} + {2'b00, a0}) > 3'd2;
    endfunction

endpackage

// File: rtl/iows_plan.sv
module iows_plan
    import iows_pkg::*;
(
    input  logic        wr,
    input  logic [1:0]  len,
    input  logic [1:0]  a_lo,
    input  logic [23:0] wdata,
    output bus_step_t   step0,
    output bus_step_t   step1,
    output logic        two
);
    always_comb begin
        step0 = mk_step(1'b0, 1'b0, 2'd0, 1'b0, 16'h0000);
        step1 = step0;
        two   = 1'b0;
        if (!wr) begin
            two   = read_spans_two(len, a_lo[0]);
            step0 = mk_step(1'b0, 1'b0, 2'd0, !two && a_lo[1], 16'h0000);
            step1 = mk_step(1'b0, 1'b0, 2'd2, 1'b1, 16'h0000);
        end else begin
            case (len)
                2'd1: step0 = mk_step(1'b1, 1'b1, 2'd0, 1'b0, {8'h00, wdata[7:0]});
                2'd2: begin
                    if (a_lo[0]) begin
                        two   = 1'b1;
                        step0 = mk_step(1'b1, 1'b1, 2'd0, 1'b0, {8'h00, wdata[7:0]});
                        step1 = mk_step(1'b1, 1'b1, 2'd1, 1'b0, {8'h00, wdata[15:8]});
                    end else begin
                        step0 = mk_step(1'b1, 1'b0, 2'd0, 1'b0, wdata[15:0]);
                    end
                end
                2'd3: begin
                    two = 1'b1;
                    if (a_lo[0]) begin
                        step0 = mk_step(1'b1, 1'b1, 2'd0, 1'b0, {8'h00, wdata[7:0]});
                        step1 = mk_step(1'b1, 1'b0, 2'd1, 1'b0, wdata[23:8]);
                    end else begin
                        step0 = mk_step(1'b1, 1'b0, 2'd0, 1'b0, wdata[15:0]);
                        step1 = mk_step(1'b1, 1'b1, 2'd2, 1'b0, {8'h00, wdata[23:16]});
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/iows_timer.sv
module iows_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clr,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (run)
            cnt <= cnt + 1'b1;
    end

    assign expire = run && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/iows_seq.sv
module iows_seq
    import iows_pkg::*;
#(
    parameter int ADDR_W      = 22,
    parameter int TIMEOUT_CYC = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_len,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [23:0]       req_wdata,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [31:0]       rd_data,
    output logic              bus_req,
    output logic              bus_write,
    output logic              bus_byte,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [15:0]       bus_wdata,
    input  logic              bus_ack,
    input  logic [15:0]       bus_rdata
);
    seq_state_e        state;
    logic              idx, two_q, two_n;
    bus_step_t         s0_q, s1_q, s0_n, s1_n, cur;
    logic [ADDR_W-1:0] base_q, raw_addr;
    logic [31:0]       rd_q;
    logic              done_q, err_q;
    logic              accept, ack_ok, last, waiting, expire;

    iows_plan u_plan (
        .wr    (req_write),
        .len   (req_len),
        .a_lo  (req_addr[1:0]),
        .wdata (req_wdata),
        .step0 (s0_n),
        .step1 (s1_n),
        .two   (two_n)
    );

    iows_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (waiting),
        .clr    (accept || ack_ok),
        .expire (expire)
    );

    assign accept   = (state == ST_IDLE) && req_valid && (req_len != 2'd0);
    assign cur      = idx ? s1_q : s0_q;
    assign ack_ok   = (state == ST_BUS) && bus_ack;
    assign waiting  = (state == ST_BUS) && !bus_ack;
    assign last     = (idx == two_q);
    assign raw_addr = base_q + ADDR_W'(cur.off);

    assign busy      = (state == ST_BUS);
    assign bus_req   = busy;
    assign bus_write = busy && cur.wr;
    assign bus_byte  = busy && cur.byte_c;
    assign bus_addr  = cur.byte_c ? raw_addr : {raw_addr[ADDR_W-1:1], 1'b0};
    assign bus_wdata = busy ? cur.wdata : 16'h0000;
    assign done      = done_q;
    assign err       = err_q;
    assign rd_data   = rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            idx    <= 1'b0;
            two_q  <= 1'b0;
            s0_q   <= '0;
            s1_q   <= '0;
            base_q <= '0;
            rd_q   <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (accept) begin
                state  <= ST_BUS;
                idx    <= 1'b0;
                two_q  <= two_n;
                s0_q   <= s0_n;
                s1_q   <= s1_n;
                base_q <= req_addr;
                rd_q   <= '0;
            end else if (ack_ok) begin
                if (!cur.wr) begin
                    if (cur.hi_lane) rd_q[31:16] <= bus_rdata;
                    else             rd_q[15:0]  <= bus_rdata;
                end
                if (last) begin
                    state  <= ST_IDLE;
                    done_q <= 1'b1;
                end else begin
                    idx <= 1'b1;
                end
            end else if (expire) begin
                state  <= ST_IDLE;
                done_q <= 1'b1;
                err_q  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/iows_seq_chk.sv
module iows_seq_chk #(
    parameter int ADDR_W = 22
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic              bus_req,
    input logic              bus_write,
    input logic              bus_byte,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [15:0]       bus_wdata,
    input logic              bus_ack
);
    logic [1:0] acks;

    always_ff @(posedge clk) begin
        if (rst || !busy)
            acks <= 2'd0;
        else if (bus_req && bus_ack)
            acks <= acks + 2'd1;
    end

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_ack |=> err || (bus_req && $stable(bus_addr) && $stable(bus_write)
                                        && $stable(bus_byte) && $stable(bus_wdata)));

    p_read_word_r4: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_write |-> !bus_byte);

    p_word_even_r2: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_byte |-> !bus_addr[0]);

    p_cycle_limit_r6: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_ack |-> acks < 2'd2);

    p_done_once_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_after_ack_r10: assert property (@(posedge clk) disable iff (rst)
        done && !err |-> $past(bus_ack) && !busy);

    p_err_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        err |-> done && !bus_req);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !bus_req);
endmodule

bind iows_seq iows_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .bus_req   (bus_req),
    .bus_write (bus_write),
    .bus_byte  (bus_byte),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack)
);

// File: tb/iows_seq_tb.sv
module iows_seq_tb;
    localparam int AW = 22;
    localparam int TO = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [1:0] req_len = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [23:0] req_wdata = '0;
    logic busy, done, err, bus_req, bus_write, bus_byte;
    logic [31:0] rd_data;
    logic [AW-1:0] bus_addr;
    logic [15:0] bus_wdata;
    logic bus_ack = 1'b0;
    logic [15:0] bus_rdata = '0;

    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    iows_seq #(.ADDR_W(AW), .TIMEOUT_CYC(TO)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_len(req_len), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .err(err), .rd_data(rd_data),
        .bus_req(bus_req), .bus_write(bus_write), .bus_byte(bus_byte),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata)
    );

    task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                       input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    function automatic logic [15:0] resp(input int a);
        return 16'((a * 7 + 32'h1234) & 32'hFFFF);
    endfunction

    function automatic logic [63:0] pk(input int wr, input int bt, input int a, input int d);
        return (64'(wr) << 39) | (64'(bt) << 38) | (64'(a & 32'h3FFFFF) << 16) | 64'(d & 32'hFFFF);
    endfunction

    task automatic run(input bit wr, input int len, input int addr, input int data,
                       input int lat, input bit hang, input string rq);
        logic [63:0] q[$];
        logic [31:0] exp_rd = '0;
        int hi_cyc = 0;
        int waitc = 0;
        bit got_done = 0;
        int w0 = addr & ~1;
        if (!wr) begin
            if (len + (addr & 1) <= 2) begin
                q.push_back(pk(0, 0, w0, 0));
                exp_rd = ((addr & 2) != 0) ? {resp(w0), 16'h0} : {16'h0, resp(w0)};
            end else begin
                q.push_back(pk(0, 0, w0, 0));
                q.push_back(pk(0, 0, w0 + 2, 0));
                exp_rd = {resp(w0 + 2), resp(w0)};
            end
        end else if (len == 1) begin
            q.push_back(pk(1, 1, addr, data & 'hFF));
        end else if (len == 2) begin
            if ((addr & 1) != 0) begin
                q.push_back(pk(1, 1, addr, data & 'hFF));
                q.push_back(pk(1, 1, addr + 1, (data >> 8) & 'hFF));
            end else q.push_back(pk(1, 0, addr, data & 'hFFFF));
        end else begin
            if ((addr & 1) != 0) begin
                q.push_back(pk(1, 1, addr, data & 'hFF));
                q.push_back(pk(1, 0, addr + 1, (data >> 8) & 'hFFFF));
            end else begin
                q.push_back(pk(1, 0, addr, data & 'hFFFF));
                q.push_back(pk(1, 1, addr + 2, (data >> 16) & 'hFF));
            end
        end
        req_write = wr; req_len = 2'(len); req_addr = AW'(addr);
        req_wdata = 24'(data); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int g = 0; g < 200; g++) begin
            if (done) begin got_done = 1; break; end
            if (bus_req) begin
                hi_cyc++;
                if (!hang) begin
                    if (q.size() == 0)
                        chk(0, {rq, " extra bus cycle"}, {62'h0, bus_write, bus_byte}, 64'h0);
                    else
                        chk({24'h0, bus_write, bus_byte, bus_addr, bus_wdata} == q[0],
                            {rq, " R8 cycle fields"},
                            {24'h0, bus_write, bus_byte, bus_addr, bus_wdata}, q[0]);
                    if (waitc == lat) begin
                        bus_ack = 1'b1;
                        bus_rdata = resp(int'(bus_addr));
                    end
                end
                waitc++;
            end
            @(negedge clk);
            if (bus_ack) begin
                bus_ack = 1'b0;
                if (q.size() > 0) void'(q.pop_front());
                waitc = 0;
            end
        end
        chk(got_done, {rq, " R10 done seen"}, 64'(got_done), 64'h1);
        chk(err == hang, {rq, " R9 err flag"}, 64'(err), 64'(hang));
        chk(!busy, {rq, " R10 busy low at done"}, 64'(busy), 64'h0);
        if (hang)
            chk(hi_cyc == TO, {rq, " R9 timeout length"}, 64'(hi_cyc), 64'(TO));
        else
            chk(q.size() == 0, {rq, " missing cycles"}, 64'(q.size()), 64'h0);
        if (!wr && !hang)
            chk(rd_data == exp_rd, {rq, " read data"}, 64'(rd_data), 64'(exp_rd));
        @(negedge clk);
        chk(!done && !bus_req, {rq, " R10 single strobe"}, {62'h0, done, bus_req}, 64'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({busy, done, err, bus_req, bus_write, bus_byte} == 6'b0 && rd_data == 32'h0,
            "R1 reset outputs", {26'h0, busy, done, err, bus_req, bus_write, bus_byte, rd_data},
            64'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !bus_req && !done, "R1 after reset",
            {61'h0, busy, bus_req, done}, 64'h0);

        // R2 / R3 / R4: reads at each offset and length
        for (int off = 0; off < 4; off++) begin
            for (int len = 1; len < 4; len++) begin
                run(1'b0, len, 32'h100 + off, 0, (off + len) % 4, 1'b0,
                    (len + (off & 1) <= 2) ? "R2 one-word read R4" : "R3 two-word read R4");
            end
        end
        // R5 / R6 / R7: writes at each offset and length
        for (int off = 0; off < 4; off++) begin
            run(1'b1, 1, 32'h2A0 + off, 32'hC3B2A1, off, 1'b0, "R5 byte write");
            run(1'b1, 2, 32'h2A0 + off, 32'hC3B2A1, off % 2, 1'b0, "R6 word write");
            run(1'b1, 3, 32'h2A0 + off, 32'hC3B2A1, 2, 1'b0, "R7 tri-byte write");
        end
        // R9: target that never answers
        run(1'b0, 3, 32'h201, 0, 0, 1'b1, "R9 read timeout");
        run(1'b1, 3, 32'h202, 32'h554433, 0, 1'b1, "R9 write timeout");
        run(1'b0, 2, 32'h203, 0, 1, 1'b0, "R9 recovery R3");

        // R11: zero-length request ignored
        req_len = 2'd0; req_write = 1'b1; req_addr = AW'(32'h300); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 5; i++) begin
            chk(!bus_req && !done && !busy, "R11 zero length ignored",
                {61'h0, bus_req, done, busy}, 64'h0);
            @(negedge clk);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule